// File: doc/BRIEF.md
# Bus-mastering DMA copy engine

This block copies a run of words from one memory region to another on a shared memory bus, so the processor does not have to move the data itself. Software writes a source address, a destination address, a word count, a block size and a mode into a few configuration registers, then sets a go bit. The engine asks for the bus on a request line, waits for the grant, and then issues a read of each source word followed by a write of that word to the destination. Both addresses advance by one word after each copied word.

Two modes decide how long the engine keeps the bus. In burst mode it keeps the bus until the whole run is copied. In stealing mode it hands the bus back after each block, waits for the grant to go away, and asks again for the next block, so the processor gets bus slots between blocks. Every memory access waits on a ready input, so memories of any latency work. When the last word is written a sticky done flag is set; it drives the interrupt line until software clears it.

Top module: `xfer_dma`

## Requirements
- R1: After reset, bus_req, mem_req and irq are all low.
- R2: Configuration writes use cfg_addr 0 for the source address, 1 for the destination address, 2 for the word count, 3 for the block size and 4 for control (bit 0 go, bit 1 stealing mode when 1, bit 2 clear done). A go write with a non-zero count raises bus_req at the second rising edge after the write edge.
- R3: bus_req stays high until bus_gnt arrives, and no memory access (mem_req) is made while bus_gnt is low.
- R4: Each word is a read of the current source address (mem_we low) followed by a write (mem_we high) of the data read to the current destination address; both addresses start at the programmed values and advance by one per word.
- R5: In burst mode (control bit 1 low) the engine raises bus_req exactly once per transfer.
- R6: In stealing mode the bus is requested once per block, i.e. ceil(count / block) times; a block size of 0 means the whole transfer is one block.
- R7: bus_req is low in the cycle right after the write that ends a block or the transfer; a new request is made only after bus_gnt has gone low.
- R8: A go with a word count of 0 sets irq at the second rising edge after the write edge and never raises bus_req.
- R9: irq stays high once set until a control write with bit 2 set; it then falls at the second rising edge after that write.
- R10: While mem_req is high and mem_ready is low, mem_req, mem_addr and mem_we stay unchanged.
- R11: While a transfer is in progress, writes to the address, count and block registers and go requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| irq | output | 1 | Done interrupt, sticky |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership grant |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable (0 read, 1 write) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory access complete this cycle |

## Verification
A configuration write is taken at one edge and turned into a registered go or clear pulse, so bus_req, the zero-count irq and the cleared irq are all due two edges after the write edge; the bench samples one cycle after the write, expecting the old value, and again one cycle later, expecting the new one. The drop of bus_req after the final write of a block is due one edge after the accepted write, and a bus monitor checks it in the next sample after that write. Copy order, addresses and data are checked per accepted access as it happens, and stalled accesses are compared against the previous cycle's sample, so slow memories are covered with latencies of zero to three wait cycles.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_REL
    } mv_state_e;

    localparam int REG_SRC  = 0;
    localparam int REG_DST  = 1;
    localparam int REG_LEN  = 2;
    localparam int REG_BLK  = 3;
    localparam int REG_CTRL = 4;

    localparam int CTRL_GO    = 0;
    localparam int CTRL_STEAL = 1;
    localparam int CTRL_CLR   = 2;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter int RW = 3,
    localparam int CW = (AW > LW) ? AW : LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [RW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          busy,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [LW-1:0] len_o,
    output logic [LW-1:0] blk_o,
    output logic          steal_o,
    output logic          go_o,
    output logic          clr_o
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic [LW-1:0] blk;
        logic          steal;
        logic          go;
        logic          clr;
    } cfg_t;

    cfg_t r_d, r_q;
    logic locked;

    always_comb begin
        r_d     = r_q;
        r_d.go  = 1'b0;
        r_d.clr = 1'b0;
        locked  = busy | r_q.go;
        if (cfg_wr) begin
            if (cfg_addr == RW'(REG_CTRL)) begin
                r_d.clr = cfg_wdata[CTRL_CLR];
                if (!locked) begin
                    r_d.steal = cfg_wdata[CTRL_STEAL];
                    r_d.go    = cfg_wdata[CTRL_GO];
                end
            end else if (!locked) begin
                case (cfg_addr)
                    RW'(REG_SRC): r_d.src = cfg_wdata[AW-1:0];
                    RW'(REG_DST): r_d.dst = cfg_wdata[AW-1:0];
                    RW'(REG_LEN): r_d.len = cfg_wdata[LW-1:0];
                    RW'(REG_BLK): r_d.blk = cfg_wdata[LW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign src_o   = r_q.src;
    assign dst_o   = r_q.dst;
    assign len_o   = r_q.len;
    assign blk_o   = r_q.blk;
    assign steal_o = r_q.steal;
    assign go_o    = r_q.go;
    assign clr_o   = r_q.clr;

    // R11: settings frozen and no new go while a transfer runs
    a_r11_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(src_o) && $stable(dst_o) && $stable(len_o) && !go_o));

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          steal,
    input  logic          clr_done,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [LW-1:0] cfg_len,
    input  logic [LW-1:0] cfg_blk,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          busy,
    output logic          irq
);

    typedef struct packed {
        mv_state_e     st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] rem;
        logic [LW-1:0] blk;
        logic [LW-1:0] blk_left;
        logic [DW-1:0] data;
        logic          steal;
        logic          done;
    } mv_t;

    mv_t  m_d, m_q;
    logic fin;

    always_comb begin
        m_d = m_q;
        fin = 1'b0;
        case (m_q.st)
            ST_IDLE: begin
                if (go) begin
                    if (cfg_len == '0) begin
                        fin = 1'b1;
                    end else begin
                        m_d.src      = cfg_src;
                        m_d.dst      = cfg_dst;
                        m_d.rem      = cfg_len;
                        m_d.blk      = (cfg_blk == '0) ? cfg_len : cfg_blk;
                        m_d.blk_left = (cfg_blk == '0) ? cfg_len : cfg_blk;
                        m_d.steal    = steal;
                        m_d.st       = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt) m_d.st = ST_RD;
            end
            ST_RD: begin
                if (mem_ready) begin
                    m_d.data = mem_rdata;
                    m_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    m_d.src = m_q.src + AW'(1);
                    m_d.dst = m_q.dst + AW'(1);
                    m_d.rem = m_q.rem - LW'(1);
                    if (m_q.blk_left == LW'(1)) m_d.blk_left = m_q.blk;
                    else                        m_d.blk_left = m_q.blk_left - LW'(1);
                    if (m_q.rem == LW'(1)) begin
                        fin    = 1'b1;
                        m_d.st = ST_IDLE;
                    end else if (m_q.steal && m_q.blk_left == LW'(1)) begin
                        m_d.st = ST_REL;
                    end else begin
                        m_d.st = ST_RD;
                    end
                end
            end
            ST_REL: begin
                if (!bus_gnt) m_d.st = ST_REQ;
            end
            default: m_d.st = ST_IDLE;
        endcase
        m_d.done = fin | (m_q.done & ~clr_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q    <= '0;
            m_q.st <= ST_IDLE;
        end else begin
            m_q <= m_d;
        end
    end

    assign bus_req   = (m_q.st == ST_REQ) || (m_q.st == ST_RD) || (m_q.st == ST_WR);
    assign mem_req   = (m_q.st == ST_RD) || (m_q.st == ST_WR);
    assign mem_we    = (m_q.st == ST_WR);
    assign mem_addr  = (m_q.st == ST_WR) ? m_q.dst : m_q.src;
    assign mem_wdata = m_q.data;
    assign busy      = (m_q.st != ST_IDLE);
    assign irq       = m_q.done;

    // R3: never touch memory without the grant
    a_r3_access_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> bus_gnt);

    // R3: request held while waiting for the grant
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    // R4: a completed read is followed by a write
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    // R7: bus released right after the final write
    a_r7_drop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && mem_req) |=> !bus_req);

    // R9: done is sticky until cleared
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_done) |=> irq);

    // R10: stalled access is held steady
    a_r10_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: rtl/xfer_dma.sv
module xfer_dma
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int LW = 16,
    parameter int RW = 3,
    localparam int CW = (AW > LW) ? AW : LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [RW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);

    logic [AW-1:0] src_w, dst_w;
    logic [LW-1:0] len_w, blk_w;
    logic          steal_w, go_w, clr_w, busy_w;

    dma_regs #(.AW(AW), .LW(LW), .RW(RW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .busy     (busy_w),
        .src_o    (src_w),
        .dst_o    (dst_w),
        .len_o    (len_w),
        .blk_o    (blk_w),
        .steal_o  (steal_w),
        .go_o     (go_w),
        .clr_o    (clr_w)
    );

    dma_mover #(.AW(AW), .DW(DW), .LW(LW)) mover_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go_w),
        .steal    (steal_w),
        .clr_done (clr_w),
        .cfg_src  (src_w),
        .cfg_dst  (dst_w),
        .cfg_len  (len_w),
        .cfg_blk  (blk_w),
        .bus_req  (bus_req),
        .bus_gnt  (bus_gnt),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata),
        .mem_ready(mem_ready),
        .busy     (busy_w),
        .irq      (irq)
    );

endmodule

// File: tb/xfer_dma_tb_top.sv
`timescale 1ns/1ps
module xfer_dma_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        irq, bus_req, mem_req, mem_we, mem_ready;
    logic        bus_gnt = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    xfer_dma dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [31:0] pat(int i);
        return 32'hC0DE_0000 | 32'(i & 255);
    endfunction

    // memory model with programmable wait states
    logic [31:0] mem [256];
    int          lat = 0;
    int          wcnt = 0;
    logic        init_req = 1'b0;
    assign mem_ready = mem_req && (wcnt == lat);
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else                       wcnt <= 0;
        if (init_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
        end else if (mem_req && mem_we && mem_ready) begin
            mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    // arbiter: grant follows request by one cycle unless blocked
    logic gnt_block = 1'b0;
    always @(posedge clk) bus_gnt <= bus_req && !gnt_block;

    // bus monitor
    int cur_src = 0, cur_dst = 0, cur_len = 0, cur_blk = 0;
    bit cur_steal = 0;
    int rd_base = 0, wr_base = 0;
    int rd_cnt = 0, wr_cnt = 0, rises = 0;
    int ord_err = 0, gnt_err = 0, drop_err = 0, wait_err = 0;
    bit prev_req = 0, prev_wait = 0, prev_we = 0, pend_drop = 0;
    logic [15:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_wait && !(mem_req && mem_addr == prev_addr && mem_we == prev_we)) wait_err++;
            prev_wait = mem_req && !mem_ready;
            prev_addr = mem_addr;
            prev_we   = mem_we;
            if (pend_drop && bus_req) drop_err++;
            pend_drop = 0;
            if (mem_req && !bus_gnt) gnt_err++;
            if (mem_req && mem_ready) begin
                if (!mem_we) begin
                    if (int'(mem_addr) != cur_src + (rd_cnt - rd_base)) ord_err++;
                    rd_cnt++;
                end else begin
                    int idx;
                    idx = wr_cnt - wr_base;
                    if (int'(mem_addr) != cur_dst + idx || mem_wdata != pat(cur_src + idx)
                        || (rd_cnt - rd_base) != idx + 1) ord_err++;
                    wr_cnt++;
                    if (idx + 1 == cur_len || (cur_steal && cur_blk != 0 && (idx + 1) % cur_blk == 0))
                        pend_drop = 1;
                end
            end
            if (bus_req && !prev_req) rises++;
            prev_req = bus_req;
        end
    end

    int total = 0, bad = 0;
    bit wd_fired = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(int a, int d);
        cfg_wr    = 1'b1;
        cfg_addr  = 3'(a);
        cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic mem_init();
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
    endtask

    task automatic setup(int s, int d, int n, int b, bit st);
        cur_src = s; cur_dst = d; cur_len = n; cur_blk = b; cur_steal = st;
        rd_base = rd_cnt; wr_base = wr_cnt;
        cfg_write(0, s);
        cfg_write(1, d);
        cfg_write(2, n);
        cfg_write(3, b);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    endtask

    // src, dst, len, blk, steal, latency, expected bus requests
    localparam logic [47:0] VEC [6] = '{
        {8'h00, 8'h80, 8'd4, 8'd2, 4'd0, 4'd0, 8'd1},
        {8'h10, 8'h90, 8'd5, 8'd2, 4'd1, 4'd1, 8'd3},
        {8'h20, 8'hA0, 8'd6, 8'd3, 4'd1, 4'd2, 8'd2},
        {8'h30, 8'hB0, 8'd3, 8'd0, 4'd1, 4'd0, 8'd1},
        {8'h40, 8'hC0, 8'd1, 8'd1, 4'd1, 4'd3, 8'd1},
        {8'h50, 8'hD0, 8'd7, 8'd1, 4'd1, 4'd0, 8'd7}
    };

    task automatic run_all();
        int r0, e0, n_bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!bus_req && !mem_req && !irq, "R1", {bus_req, mem_req, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_req && !mem_req && !irq, "R1", {bus_req, mem_req, irq}, 0);

        for (int v = 0; v < 6; v++) begin
            logic [47:0] t;
            t = VEC[v];
            mem_init();
            lat = int'(t[11:8]);
            setup(int'(t[47:40]), int'(t[39:32]), int'(t[31:24]), int'(t[23:16]), t[12]);
            r0 = rises; e0 = ord_err + gnt_err + drop_err + wait_err;
            cfg_write(4, t[12] ? 3 : 1);
            wait_irq();
            chk(irq == 1'b1, "R9", irq, 1);
            chk(rises - r0 == int'(t[7:0]), t[12] ? "R6" : "R5", rises - r0, int'(t[7:0]));
            chk(drop_err == 0, "R7", drop_err, 0);
            chk(ord_err + gnt_err + wait_err == 0, "R4 R3 R10", ord_err + gnt_err + wait_err, 0);
            n_bad = 0;
            for (int i = 0; i < cur_len; i++) if (mem[cur_dst + i] != pat(cur_src + i)) n_bad++;
            chk(n_bad == 0, "R4", n_bad, 0);
            chk(mem[cur_dst + cur_len] == pat(cur_dst + cur_len), "R4", 0, 0);
            // R9: sticky, then cleared two edges after the write
            repeat (5) @(negedge clk);
            chk(irq == 1'b1, "R9", irq, 1);
            cfg_write(4, 4);
            chk(irq == 1'b1, "R9", irq, 1);
            @(negedge clk);
            chk(irq == 1'b0, "R9", irq, 0);
            if (e0 != ord_err + gnt_err + drop_err + wait_err) ;
        end

        // R2: request timing after the go write
        mem_init();
        lat = 0;
        setup(8'h05, 8'h85, 2, 0, 0);
        cfg_write(4, 1);
        chk(bus_req == 1'b0, "R2", bus_req, 0);
        @(negedge clk);
        chk(bus_req == 1'b1, "R2", bus_req, 1);
        wait_irq();
        cfg_write(4, 4);
        @(negedge clk);

        // R8: zero count
        r0 = rises;
        setup(8'h06, 8'h86, 0, 0, 0);
        cfg_write(4, 1);
        chk(irq == 1'b0, "R8", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R8", irq, 1);
        repeat (4) @(negedge clk);
        chk(rises == r0, "R8", rises - r0, 0);
        cfg_write(4, 4);
        @(negedge clk);

        // R3: request held while grant withheld
        gnt_block = 1'b1;
        setup(8'h07, 8'h87, 2, 0, 0);
        cfg_write(4, 1);
        repeat (8) @(negedge clk);
        chk(bus_req == 1'b1 && mem_req == 1'b0, "R3", {bus_req, mem_req}, 2);
        gnt_block = 1'b0;
        wait_irq();
        chk(mem[8'h87] == pat(8'h07) && mem[8'h88] == pat(8'h08), "R3", 0, 0);
        cfg_write(4, 4);
        @(negedge clk);

        // R11: writes during a transfer are ignored
        mem_init();
        lat = 3;
        r0 = rises;
        setup(8'h00, 8'h80, 4, 0, 0);
        cfg_write(4, 1);
        repeat (3) @(negedge clk);
        cfg_write(0, 8'h60);
        cfg_write(2, 1);
        cfg_write(4, 1);
        wait_irq();
        n_bad = 0;
        for (int i = 0; i < 4; i++) if (mem[8'h80 + i] != pat(i)) n_bad++;
        chk(n_bad == 0 && rises - r0 == 1, "R11", n_bad, 0);
        cfg_write(4, 4);
        @(negedge clk);
        // source and count registers still hold their values: next copy uses 0x00 and 4
        cur_dst = 8'hE0; rd_base = rd_cnt; wr_base = wr_cnt;
        cfg_write(1, 8'hE0);
        cfg_write(4, 1);
        wait_irq();
        chk(mem[8'hE0] == pat(0) && mem[8'hE3] == pat(3), "R11", 0, 0);
        chk(ord_err + gnt_err + drop_err + wait_err == 0, "R10", ord_err + gnt_err + drop_err + wait_err, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_fired = 1;
            end
        join_any
        disable fork;
        if (wd_fired) chk(0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule